// File: doc/BRIEF.md
# Doubleword Load/Store Address Unit

This unit carries out a register-pair load or store as two 32-bit memory accesses. A start strobe presents the decoded instruction fields: the operation code, pre/post indexing, offset direction, writeback, the first register number and an 8-bit offset. It also presents the current base register value and, for a store, the two register values to be written. The unit computes the offset base and the access address, then checks the instruction for an odd first register and for 8-byte alignment.

If both checks pass, the unit issues two accesses on a valid/ready memory port. The lower word is at the access address and the upper word is at that address plus 4. Once both accesses are done, the unit raises a one-cycle done pulse. In that cycle it offers the loaded pair and, when required, the updated base, so the register file can write them back.

A faulting instruction makes no memory access. It finishes with a done pulse that carries either the undefined flag or the abort flag. The register file, the caches and exception entry are outside this block.

Top module: `dword_ls_unit`

## Requirements
- R1: The offset base is base+offset when up_i is 1 and base-offset when up_i is 0. The access address is the offset base when pre_i is 1 and the unmodified base when pre_i is 0.
- R2: A start in idle is accepted only when op_i is 4'hD (load) or 4'hF (store). With any other op_i code the start is ignored: no memory request and no done pulse.
- R3: If rd_i[0] is 1, the instruction is undefined. done_o and undef_o are high together in the cycle after the start edge. No memory request is made, and rd_we_o and base_we_o stay low. Undefined takes priority over misalignment.
- R4: If the access address has a nonzero value in bits [2:0], done_o and abort_o are high together in the cycle after the start edge. No memory request is made, and no write-back is signalled.
- R5: An aligned instruction makes exactly two requests, in this order: the first at the access address and the second at the access address + 4. A request holds its address, direction and data stable until mem_ready_i is high.
- R6: For a load, mem_we_o is 0. rd_lo_o and rd_hi_o return the data of the first and second access, and rd_we_o is high in the done cycle. rd_o returns the first register number, and the pair is rd_o and rd_o+1.
- R7: For a store, mem_we_o is 1. st_lo_i is written by the first access and st_hi_i by the second. rd_we_o stays low.
- R8: base_we_o is high only in the done cycle of a successful instruction, and only when wb_i is 1 or pre_i is 0. In that cycle base_o equals the offset base.
- R9: done_o is a single-cycle pulse, raised exactly once per accepted instruction. A start that arrives while an instruction is in progress is ignored.
- R10: With mem_ready_i held high, done_o of a successful instruction is high in the third cycle after the start edge. Each cycle that mem_ready_i is low while a request is pending delays done_o by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction strobe, taken in idle |
| op_i | input | 4 | Operation code: D load, F store |
| pre_i | input | 1 | 1 pre-indexed, 0 post-indexed |
| up_i | input | 1 | 1 add offset, 0 subtract |
| wb_i | input | 1 | Writeback request |
| rd_i | input | 4 | First register of the pair |
| off_i | input | 8 | Unsigned byte offset |
| base_i | input | 32 | Base register value |
| st_lo_i | input | 32 | Store data for the first register |
| st_hi_i | input | 32 | Store data for the second register |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Byte address of the word access |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts the request |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| done_o | output | 1 | Instruction finished |
| undef_o | output | 1 | Undefined instruction, with done_o |
| abort_o | output | 1 | Alignment abort, with done_o |
| rd_o | output | 4 | First register of the pair |
| rd_we_o | output | 1 | Write loaded pair, with done_o |
| rd_lo_o | output | 32 | Loaded word for rd_o |
| rd_hi_o | output | 32 | Loaded word for rd_o+1 |
| base_we_o | output | 1 | Write back the base, with done_o |
| base_o | output | 32 | Updated base value |

## Verification
A faulting instruction reports in the first cycle after its start edge. A clean instruction reports in the third cycle when memory never stalls, and one cycle later for every stalled cycle. The bench counts sampling points, one per falling edge after the start edge. It compares that count with the expected latency only in runs where mem_ready_i stays high. The memory model logs each handshake on the falling edge before the rising edge that takes it. The done-cycle outputs are read at the same point where done_o is first seen high, and the pulse counts are read again a few cycles later.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam logic [3:0] OP_LOAD  = 4'hD;
  localparam logic [3:0] OP_STORE = 4'hF;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_FIN  = 2'd3
  } dls_state_e;
endpackage

// File: rtl/dls_addr_gen.sv
module dls_addr_gen #(
  parameter int AW = 32,
  parameter int OW = 8,
  parameter int ALIGN_BITS = 3
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  input  logic          up_i,
  input  logic          pre_i,
  output logic [AW-1:0] acc_addr_o,
  output logic [AW-1:0] new_base_o,
  output logic          misalign_o
);
  logic [AW-1:0] off_ext;
  assign off_ext    = AW'(off_i);
  assign new_base_o = up_i ? (base_i + off_ext) : (base_i - off_ext);
  assign acc_addr_o = pre_i ? new_base_o : base_i;
  assign misalign_o = |acc_addr_o[ALIGN_BITS-1:0];
endmodule

// File: rtl/dls_seq.sv
module dls_seq
  import dls_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          load_i,
  input  logic [RW-1:0] rd_i,
  input  logic          wb_eff_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [AW-1:0] new_base_i,
  input  logic          misalign_i,
  input  logic [DW-1:0] st_lo_i,
  input  logic [DW-1:0] st_hi_i,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          done_o,
  output logic          undef_o,
  output logic          abort_o,
  output logic [RW-1:0] rd_o,
  output logic          rd_we_o,
  output logic [DW-1:0] rd_lo_o,
  output logic [DW-1:0] rd_hi_o,
  output logic          base_we_o,
  output logic [AW-1:0] base_o
);
  dls_state_e    state_q;
  logic [AW-1:0] addr_q, nbase_q;
  logic [DW-1:0] wlo_q, whi_q, rlo_q, rhi_q;
  logic [RW-1:0] rd_q;
  logic          load_q, bwe_q, undef_q, abort_q;
  logic          accept, fault, ok;

  assign accept = (state_q == ST_IDLE) && go_i;
  assign fault  = rd_i[0] | misalign_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      nbase_q <= '0;
      wlo_q   <= '0;
      whi_q   <= '0;
      rlo_q   <= '0;
      rhi_q   <= '0;
      rd_q    <= '0;
      load_q  <= 1'b0;
      bwe_q   <= 1'b0;
      undef_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q  <= acc_addr_i;
          nbase_q <= new_base_i;
          wlo_q   <= st_lo_i;
          whi_q   <= st_hi_i;
          rd_q    <= rd_i;
          load_q  <= load_i;
          bwe_q   <= wb_eff_i;
          undef_q <= rd_i[0];
          abort_q <= ~rd_i[0] & misalign_i;
          state_q <= fault ? ST_FIN : ST_LO;
        end
        ST_LO: if (mem_ready_i) begin
          if (load_q) rlo_q <= mem_rdata_i;
          state_q <= ST_HI;
        end
        ST_HI: if (mem_ready_i) begin
          if (load_q) rhi_q <= mem_rdata_i;
          state_q <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = (state_q == ST_LO) || (state_q == ST_HI);
  assign mem_we_o    = mem_req_o && !load_q;
  assign mem_addr_o  = (state_q == ST_HI) ? addr_q + AW'(WORD_BYTES) : addr_q;
  assign mem_wdata_o = (state_q == ST_HI) ? whi_q : wlo_q;

  assign done_o    = (state_q == ST_FIN);
  assign undef_o   = done_o && undef_q;
  assign abort_o   = done_o && abort_q;
  assign ok        = done_o && !undef_q && !abort_q;
  assign rd_we_o   = ok && load_q;
  assign base_we_o = ok && bwe_q;
  assign base_o    = nbase_q;
  assign rd_o      = rd_q;
  assign rd_lo_o   = rlo_q;
  assign rd_hi_o   = rhi_q;
endmodule

// File: rtl/dword_ls_unit.sv
module dword_ls_unit
  import dls_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int OW = 8,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    op_i,
  input  logic          pre_i,
  input  logic          up_i,
  input  logic          wb_i,
  input  logic [RW-1:0] rd_i,
  input  logic [OW-1:0] off_i,
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] st_lo_i,
  input  logic [DW-1:0] st_hi_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o,
  output logic          undef_o,
  output logic          abort_o,
  output logic [RW-1:0] rd_o,
  output logic          rd_we_o,
  output logic [DW-1:0] rd_lo_o,
  output logic [DW-1:0] rd_hi_o,
  output logic          base_we_o,
  output logic [AW-1:0] base_o
);
  localparam int WORD_BYTES = DW / 8;
  localparam int ALIGN_BITS = $clog2(2 * WORD_BYTES);

  logic          is_load, is_store;
  logic [AW-1:0] acc_addr, new_base;
  logic          misalign;

  assign is_load  = (op_i == OP_LOAD);
  assign is_store = (op_i == OP_STORE);

  dls_addr_gen #(.AW(AW), .OW(OW), .ALIGN_BITS(ALIGN_BITS)) u_addr (
    .base_i     (base_i),
    .off_i      (off_i),
    .up_i       (up_i),
    .pre_i      (pre_i),
    .acc_addr_o (acc_addr),
    .new_base_o (new_base),
    .misalign_o (misalign)
  );

  dls_seq #(.AW(AW), .DW(DW), .RW(RW), .WORD_BYTES(WORD_BYTES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (start_i && (is_load || is_store)),
    .load_i      (is_load),
    .rd_i        (rd_i),
    .wb_eff_i    (wb_i || !pre_i),
    .acc_addr_i  (acc_addr),
    .new_base_i  (new_base),
    .misalign_i  (misalign),
    .st_lo_i     (st_lo_i),
    .st_hi_i     (st_hi_i),
    .mem_ready_i (mem_ready_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .done_o      (done_o),
    .undef_o     (undef_o),
    .abort_o     (abort_o),
    .rd_o        (rd_o),
    .rd_we_o     (rd_we_o),
    .rd_lo_o     (rd_lo_o),
    .rd_hi_o     (rd_hi_o),
    .base_we_o   (base_we_o),
    .base_o      (base_o)
  );
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i,
  input logic          done_o,
  input logic          undef_o,
  input logic          abort_o,
  input logic          rd_we_o,
  input logic          base_we_o
);
  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
                                     && $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_second_word_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i && !mem_addr_o[2])
      |=> (mem_req_o && mem_addr_o == $past(mem_addr_o) + 32'd4));

  p_first_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> (mem_addr_o[2:0] == 3'b000));

  p_flags_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undef_o || abort_o) |-> (done_o && $onehot0({undef_o, abort_o}) && !rd_we_o && !base_we_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_req_at_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  p_base_we_in_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_we_o || rd_we_o) |-> done_o);
endmodule

bind dword_ls_unit dls_checker #(.AW(AW), .DW(DW)) u_dls_checker (.*);

// File: tb/tb_dword_ls_unit.sv
`timescale 1ns/1ps
module tb_dword_ls_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = 4'h0;
  logic        pre = 1'b0, up = 1'b0, wb = 1'b0;
  logic [3:0]  rd = 4'h0;
  logic [7:0]  off = 8'h0;
  logic [31:0] base = '0, st_lo = '0, st_hi = '0;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, undef, abort_f, rd_we, base_we;
  logic [3:0]  rd_out;
  logic [31:0] rd_lo, rd_hi, base_out;

  int n_chk = 0, n_bad = 0;
  int n_acc = 0, n_done = 0, n_bwe = 0;
  logic [31:0] acc_addr [4];
  logic        acc_we   [4];
  logic [31:0] acc_wd   [4];
  logic        stall_en = 1'b0;
  int          tick = 0;

  always #2 clk = ~clk;

  dword_ls_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .pre_i(pre), .up_i(up),
    .wb_i(wb), .rd_i(rd), .off_i(off), .base_i(base), .st_lo_i(st_lo), .st_hi_i(st_hi),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata), .done_o(done), .undef_o(undef),
    .abort_o(abort_f), .rd_o(rd_out), .rd_we_o(rd_we), .rd_lo_o(rd_lo), .rd_hi_o(rd_hi),
    .base_we_o(base_we), .base_o(base_out)
  );

  // memory model: set ready/rdata for the coming rising edge, then log the handshake
  always @(negedge clk) begin
    tick++;
    mem_ready = stall_en ? tick[0] : 1'b1;
    mem_rdata = ~mem_addr;
    if (mem_req && mem_ready) begin
      if (n_acc < 4) begin
        acc_addr[n_acc] = mem_addr;
        acc_we[n_acc]   = mem_we;
        acc_wd[n_acc]   = mem_wdata;
      end
      n_acc++;
    end
    if (done) n_done++;
    if (base_we) n_bwe++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  typedef struct packed {
    logic [3:0]  op;
    logic        pre, up, wb;
    logic [3:0]  rd;
    logic [7:0]  off;
    logic [31:0] base;
    logic [1:0]  kind;   // 0 ok, 1 undef, 2 abort
    logic [31:0] addr;
    logic        bwe;
    logic [31:0] nbase;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{4'hD, 1'b1, 1'b1, 1'b0, 4'd2,  8'h08, 32'h0000_1000, 2'd0, 32'h0000_1008, 1'b0, 32'h0000_1008},
    '{4'hD, 1'b1, 1'b0, 1'b1, 4'd4,  8'h10, 32'h0000_2000, 2'd0, 32'h0000_1FF0, 1'b1, 32'h0000_1FF0},
    '{4'hF, 1'b0, 1'b1, 1'b0, 4'd6,  8'h20, 32'h0000_3000, 2'd0, 32'h0000_3000, 1'b1, 32'h0000_3020},
    '{4'hF, 1'b1, 1'b1, 1'b1, 4'd0,  8'h00, 32'h0000_4008, 2'd0, 32'h0000_4008, 1'b1, 32'h0000_4008},
    '{4'hD, 1'b1, 1'b1, 1'b0, 4'd3,  8'h08, 32'h0000_1000, 2'd1, 32'h0000_1008, 1'b0, 32'h0000_1008},
    '{4'hD, 1'b1, 1'b1, 1'b1, 4'd2,  8'h04, 32'h0000_1000, 2'd2, 32'h0000_1004, 1'b0, 32'h0000_1004},
    '{4'hF, 1'b0, 1'b0, 1'b0, 4'd8,  8'h08, 32'h0000_5004, 2'd2, 32'h0000_5004, 1'b0, 32'h0000_4FFC},
    '{4'hF, 1'b0, 1'b0, 1'b0, 4'd14, 8'h18, 32'h0000_6000, 2'd0, 32'h0000_6000, 1'b1, 32'h0000_5FE8},
    '{4'hD, 1'b1, 1'b1, 1'b1, 4'd5,  8'h02, 32'h0000_7000, 2'd1, 32'h0000_7002, 1'b0, 32'h0000_7002}
  };

  task automatic clear_logs();
    n_acc = 0; n_done = 0; n_bwe = 0;
  endtask

  // issue one instruction and return the number of sampling points until done_o
  task automatic issue(input vec_t v, input logic [31:0] lo, input logic [31:0] hi, output int cyc);
    clear_logs();
    op = v.op; pre = v.pre; up = v.up; wb = v.wb; rd = v.rd; off = v.off; base = v.base;
    st_lo = lo; st_hi = hi; start = 1'b1;
    tick_n(1);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 1) begin
      cyc++;
      if (!done) begin end
    end
    cyc = 1;
    while (!done && cyc < 40) begin
      tick_n(1);
      cyc++;
    end
  endtask

  task automatic check_vec(input vec_t v, input int idx, input bit timed);
    int cyc;
    logic [31:0] lo, hi;
    lo = 32'hA5A5_0000 | idx;
    hi = 32'h5A5A_0000 | idx;
    issue(v, lo, hi, cyc);
    chk(done === 1'b1, "R9 done seen", {31'd0, done}, 32'd1);
    if (v.kind == 2'd1) begin
      chk(undef === 1'b1 && abort_f === 1'b0, "R3 undef flag", {30'd0, undef, abort_f}, 32'd2);
      chk(cyc == 1, "R3 latency", cyc, 1);
      chk(n_acc == 0 && !rd_we && !base_we, "R3 no access/writeback", n_acc, 0);
    end else if (v.kind == 2'd2) begin
      chk(abort_f === 1'b1 && undef === 1'b0, "R4 abort flag", {30'd0, undef, abort_f}, 32'd1);
      chk(cyc == 1, "R4 latency", cyc, 1);
      chk(n_acc == 0 && !rd_we && !base_we, "R4 no access/writeback", n_acc, 0);
    end else begin
      chk(!undef && !abort_f, "R5 no fault flags", {30'd0, undef, abort_f}, 0);
      if (timed) chk(cyc == 3, "R10 latency", cyc, 3);
      else       chk(cyc > 3, "R10 stalled latency", cyc, 4);
      chk(n_acc == 2, "R5 access count", n_acc, 2);
      chk(acc_addr[0] == v.addr, "R1 first address", acc_addr[0], v.addr);
      chk(acc_addr[1] == v.addr + 32'd4, "R5 second address", acc_addr[1], v.addr + 32'd4);
      chk(base_we === v.bwe, "R8 base write enable", {31'd0, base_we}, {31'd0, v.bwe});
      if (v.bwe) chk(base_out == v.nbase, "R8 base value", base_out, v.nbase);
      chk(rd_out == v.rd, "R6 register number", {28'd0, rd_out}, {28'd0, v.rd});
      if (v.op == 4'hD) begin
        chk(!acc_we[0] && !acc_we[1], "R6 read direction", {30'd0, acc_we[0], acc_we[1]}, 0);
        chk(rd_we === 1'b1, "R6 rd_we", {31'd0, rd_we}, 1);
        chk(rd_lo == ~v.addr, "R6 low word", rd_lo, ~v.addr);
        chk(rd_hi == ~(v.addr + 32'd4), "R6 high word", rd_hi, ~(v.addr + 32'd4));
      end else begin
        chk(acc_we[0] && acc_we[1], "R7 write direction", {30'd0, acc_we[0], acc_we[1]}, 3);
        chk(rd_we === 1'b0, "R7 no rd_we", {31'd0, rd_we}, 0);
        chk(acc_wd[0] == lo, "R7 first data", acc_wd[0], lo);
        chk(acc_wd[1] == hi, "R7 second data", acc_wd[1], hi);
      end
    end
    tick_n(3);
    chk(n_done == 1, "R9 one done pulse", n_done, 1);
    chk(n_bwe == (v.kind == 2'd0 ? int'(v.bwe) : 0), "R8 base write count", n_bwe, v.bwe);
  endtask

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    mem_ready = 1'b1;
    mem_rdata = '0;
    tick_n(3);
    // reset state
    chk(!done && !mem_req && !base_we && !rd_we && !undef && !abort_f, "R9 reset outputs",
        {26'd0, done, mem_req, base_we, rd_we, undef, abort_f}, 0);
    rst_n = 1'b1;
    tick_n(2);

    for (int i = 0; i < NV; i++) check_vec(VECS[i], i, 1'b1);

    // R2: unsupported op code ignored
    clear_logs();
    op = 4'hB; pre = 1'b1; up = 1'b1; wb = 1'b1; rd = 4'd2; off = 8'h08; base = 32'h100;
    start = 1'b1;
    tick_n(1);
    start = 1'b0;
    tick_n(6);
    chk(n_done == 0 && n_acc == 0 && n_bwe == 0, "R2 other op ignored", n_done + n_acc, 0);

    // R10/R5: stalled memory, request held
    stall_en = 1'b1;
    check_vec(VECS[0], 20, 1'b0);
    check_vec(VECS[2], 21, 1'b0);
    stall_en = 1'b0;

    // R9: start held high while busy is ignored
    clear_logs();
    op = 4'hD; pre = 1'b1; up = 1'b1; wb = 1'b0; rd = 4'd10; off = 8'h10; base = 32'h8000;
    start = 1'b1;
    while (!done) tick_n(1);
    start = 1'b0;
    tick_n(4);
    chk(n_acc == 2, "R9 busy start ignored, accesses", n_acc, 2);
    chk(n_done == 1, "R9 busy start ignored, done", n_done, 1);
    chk(acc_addr[0] == 32'h8010, "R1 pre up address", acc_addr[0], 32'h8010);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule